// File: doc/BRIEF.md
# Serial Memory SPI Slave Front-End

This block is the slave side of a byte-addressed serial memory. A host drives a chip select, a serial clock and a data-in line, and gets bytes back on a data-out line that has its own output-enable. Each transaction starts with a command byte. Read and write commands then take a 24-bit address and stream data bytes, most significant bit first, until chip select rises. The block also holds an 8-bit status register that contains a write-enable latch, and a small on-chip array so that it works without other parts.

All three host pins are resynchronised into the system clock domain, and SCK edges are found by comparing successive samples. The SPI clock therefore has to stay well below the system clock: each SCK phase must last at least four system cycles. At every falling edge of chip select the block chooses clock-idle-low or clock-idle-high operation from the SCK level it samples. Data is taken on SCK rising edges and driven out on SCK falling edges in both cases. A command byte it does not recognise leaves it silent until the next selection. The SPI interface has no valid/ready flow control: the host controls the pace through SCK.

Top module: `spi_mem_slave`

## Requirements
- R1: The first 8 bits after chip select falls form the command. The commands are 0x06 (set the write latch), 0x04 (clear the write latch), 0x05 (read status), 0x01 (write status), 0x03 (read memory) and 0x02 (write memory).
- R2: After any other command byte, all further SI bits are ignored and the output-enable stays low until chip select falls again.
- R3: Command, address, data and status bytes are all shifted most significant bit first, in both directions.
- R4: Read and write commands take a 24-bit address. The upper 5 bits are ignored and the lower 19 bits are used. The array decodes the low log2(depth) bits of that address.
- R5: The SCK level at the falling edge of chip select selects the mode: low selects idle-low, high selects idle-high. SI is captured on SCK rising edges. In idle-high mode, a rise is counted only after SCK has first gone low.
- R6: SO changes only on SCK falling edges. The output-enable is high only while selected in a read-memory or read-status data phase. It goes low within one system cycle after chip select is seen high.
- R7: Read status returns the status byte and repeats it for every further byte. Status bit 1 is the write latch and bit 0 always reads 0. Write status loads bits 7:2 from the first data byte.
- R8: Write memory and write status have an effect only while the write latch is set. When chip select rises after either of these commands, the write latch is cleared.
- R9: Read and write stream bytes until deselection. The address advances by one after each byte and wraps from 0x7FFFF to 0.
- R10: Chip select high discards any partially shifted byte and returns the block to command reception.
- R11: After reset the status byte is 0x00, the array holds zeros and the output-enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck_i | input | 1 | Serial clock from host |
| spi_csn_i | input | 1 | Active-low chip select |
| spi_si_i | input | 1 | Serial data from host |
| spi_so_o | output | 1 | Serial data to host |
| spi_so_oe_o | output | 1 | Output-enable for spi_so_o |

## Verification
If the bit counter or the state machine holds a wrong value, the next status read shows it as a shifted or wrong byte. A write latch left in the wrong state shows up on the following status read or as a missed or spurious array write. A wrong address counter shows up on the first mismatching byte of a streamed read, so a full-array write followed by a read-back points to the offending address within one byte time. An unintended drive during the silent state shows up as the output-enable going high while the bytes after an invalid command are shifted in.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  typedef enum logic [7:0] {
    CMD_WRSR  = 8'h01,
    CMD_WRITE = 8'h02,
    CMD_READ  = 8'h03,
    CMD_WRDI  = 8'h04,
    CMD_RDSR  = 8'h05,
    CMD_WREN  = 8'h06
  } cmd_e;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR,
    ST_RDATA,
    ST_WDATA,
    ST_SR_OUT,
    ST_SR_IN,
    ST_DONE,
    ST_MUTE
  } phase_e;

  localparam int WLATCH_BIT = 1;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic pin_s_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], pin_i};
  end

  assign pin_s_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] cell_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= '0;
    end else if (we_i) begin
      cell_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = cell_q[addr_i];
endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int ADDR_BYTES = 3,
  parameter int AW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_s_i,
  input  logic          csn_s_i,
  input  logic          si_s_i,
  input  logic [7:0]    mem_rdata_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  output logic          so_o,
  output logic          so_oe_o
);
  localparam int ACNT_W = $clog2(ADDR_BYTES + 1);

  logic              sck_d_q, csn_d_q;
  logic              mode3_q, armed_q;
  phase_e            phase_q;
  logic [2:0]        bit_idx_q;
  logic [6:0]        rx_q;
  logic [7:0]        tx_q;
  logic [7:0]        stat_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ACNT_W-1:0] acnt_q;
  logic              wr_cmd_q, rd_cmd_q;
  logic              so_q, oe_q;

  logic       cs_fall, cs_rise, sck_rise, sck_fall, take_bit, byte_end;
  logic [7:0] byte_in, tx_src;

  assign cs_fall  = csn_d_q & ~csn_s_i;
  assign cs_rise  = ~csn_d_q & csn_s_i;
  assign sck_rise = ~sck_d_q & sck_s_i;
  assign sck_fall = sck_d_q & ~sck_s_i;
  assign take_bit = sck_rise & armed_q & ~csn_s_i & ~cs_fall;
  assign byte_end = take_bit & (bit_idx_q == 3'd7);
  assign byte_in  = {rx_q, si_s_i};
  assign tx_src   = (phase_q == ST_RDATA) ? mem_rdata_i : stat_q;

  assign mem_addr_o  = addr_q[AW-1:0];
  assign mem_wdata_o = byte_in;
  assign mem_we_o    = byte_end & (phase_q == ST_WDATA) & stat_q[WLATCH_BIT];
  assign so_o        = so_q;
  assign so_oe_o     = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d_q   <= 1'b0;
      csn_d_q   <= 1'b1;
      mode3_q   <= 1'b0;
      armed_q   <= 1'b0;
      phase_q   <= ST_CMD;
      bit_idx_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      stat_q    <= '0;
      addr_q    <= '0;
      acnt_q    <= '0;
      wr_cmd_q  <= 1'b0;
      rd_cmd_q  <= 1'b0;
      so_q      <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      sck_d_q <= sck_s_i;
      csn_d_q <= csn_s_i;
      if (csn_s_i) begin
        phase_q   <= ST_CMD;
        bit_idx_q <= '0;
        armed_q   <= 1'b0;
        oe_q      <= 1'b0;
        if (cs_rise && wr_cmd_q) stat_q[WLATCH_BIT] <= 1'b0;
        wr_cmd_q  <= 1'b0;
      end else if (cs_fall) begin
        mode3_q   <= sck_s_i;
        armed_q   <= ~sck_s_i;
        phase_q   <= ST_CMD;
        bit_idx_q <= '0;
      end else begin
        if (sck_fall) begin
          armed_q <= 1'b1;
          if (phase_q == ST_RDATA || phase_q == ST_SR_OUT) begin
            oe_q <= 1'b1;
            if (bit_idx_q == 3'd0) begin
              tx_q <= tx_src;
              so_q <= tx_src[7];
            end else begin
              so_q <= tx_q[~bit_idx_q];
            end
          end
        end
        if (take_bit) begin
          rx_q      <= byte_in[6:0];
          bit_idx_q <= bit_idx_q + 3'd1;
        end
        if (byte_end) begin
          unique case (phase_q)
            ST_CMD: begin
              unique case (byte_in)
                CMD_WREN:  begin stat_q[WLATCH_BIT] <= 1'b1; phase_q <= ST_DONE; end
                CMD_WRDI:  begin stat_q[WLATCH_BIT] <= 1'b0; phase_q <= ST_DONE; end
                CMD_RDSR:  phase_q <= ST_SR_OUT;
                CMD_WRSR:  begin wr_cmd_q <= 1'b1; phase_q <= ST_SR_IN; end
                CMD_READ:  begin rd_cmd_q <= 1'b1; acnt_q <= '0; phase_q <= ST_ADDR; end
                CMD_WRITE: begin
                  rd_cmd_q <= 1'b0; wr_cmd_q <= 1'b1; acnt_q <= '0; phase_q <= ST_ADDR;
                end
                default:   phase_q <= ST_MUTE;
              endcase
            end
            ST_ADDR: begin
              addr_q <= ADDR_W'({addr_q, byte_in});
              acnt_q <= acnt_q + 1'b1;
              if (acnt_q == ACNT_W'(ADDR_BYTES - 1))
                phase_q <= rd_cmd_q ? ST_RDATA : ST_WDATA;
            end
            ST_RDATA, ST_WDATA: addr_q <= addr_q + 1'b1;
            ST_SR_IN: begin
              if (stat_q[WLATCH_BIT]) stat_q[7:2] <= byte_in[7:2];
              phase_q <= ST_DONE;
            end
            default: ;
          endcase
        end
      end
    end
  end

  AST_OE_DROPS_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s_i |=> !oe_q);  // R6
  AST_MUTE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == ST_MUTE) |-> !oe_q);  // R2
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!csn_s_i && !cs_fall) |=> $stable(mode3_q));  // R5
  AST_BITCNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s_i |=> (bit_idx_q == 3'd0));  // R10
  AST_LATCH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && wr_cmd_q) |=> !stat_q[WLATCH_BIT]);  // R8
  AST_BIT0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_q[0]);  // R7
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int DEPTH       = 256,
  parameter int ADDR_W      = 19,
  parameter int ADDR_BYTES  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck_i,
  input  logic spi_csn_i,
  input  logic spi_si_i,
  output logic spi_so_o,
  output logic spi_so_oe_o
);
  localparam int AW   = $clog2(DEPTH);
  localparam int NPIN = 3;
  localparam logic [NPIN-1:0] PIN_RST = 3'b010;

  logic [NPIN-1:0] pin_raw, pin_s;
  logic            mem_we;
  logic [AW-1:0]   mem_addr;
  logic [7:0]      mem_wdata, mem_rdata;

  assign pin_raw = {spi_si_i, spi_csn_i, spi_sck_i};

  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    spi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_RST[g])) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_raw[g]), .pin_s_o(pin_s[g])
    );
  end

  spi_mem_ctrl #(.ADDR_W(ADDR_W), .ADDR_BYTES(ADDR_BYTES), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sck_s_i(pin_s[0]), .csn_s_i(pin_s[1]), .si_s_i(pin_s[2]),
    .mem_rdata_i(mem_rdata), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .so_o(spi_so_o), .so_oe_o(spi_so_oe_o)
  );

  spi_mem_array #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we_i(mem_we), .addr_i(mem_addr),
    .wdata_i(mem_wdata), .rdata_o(mem_rdata)
  );
endmodule

// File: tb/spi_mem_slave_tb_top.sv
`timescale 1ns/1ps
module spi_mem_slave_tb_top;
  localparam int HALF = 80;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, si = 1'b0;
  logic so, so_oe;
  int   n_chk = 0, n_bad = 0;
  logic m3 = 1'b0;
  logic [7:0] rb;

  always #5 clk = ~clk;

  spi_mem_slave dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sck_i(sck), .spi_csn_i(csn),
    .spi_si_i(si), .spi_so_o(so), .spi_so_oe_o(so_oe)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic sel(input logic mode3);
    m3 = mode3; sck = mode3; #(HALF * 2);
    csn = 1'b0; #(HALF * 2);
  endtask

  task automatic xbits(input int n, input logic [7:0] tx, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      sck = 1'b0; si = tx[i]; #HALF;
      rx[i] = so; sck = 1'b1; #HALF;
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    xbits(8, tx, rx);
  endtask

  task automatic desel;
    sck = m3; #HALF; csn = 1'b1; #(HALF * 4);
  endtask

  task automatic cmd1(input logic mode3, input logic [7:0] op);
    sel(mode3); xbyte(op, rb); desel();
  endtask

  task automatic rdsr(input logic mode3, output logic [7:0] v);
    sel(mode3); xbyte(8'h05, rb); xbyte(8'h00, v); desel();
  endtask

  task automatic hdr(input logic [7:0] op, input logic [23:0] a);
    xbyte(op, rb); xbyte(a[23:16], rb); xbyte(a[15:8], rb); xbyte(a[7:0], rb);
  endtask

  task automatic rd1(input logic mode3, input logic [23:0] a, output logic [7:0] v);
    sel(mode3); hdr(8'h03, a); xbyte(8'h00, v); desel();
  endtask

  initial begin
    #1_800_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v, v2;
    #100 rst_n = 1'b1; #200;
    chk("R11 oe after reset", {7'd0, so_oe}, 8'h00);
    rdsr(1'b0, v); chk("R11 R7 status after reset", v, 8'h00);

    // R8: write without latch is dropped
    sel(1'b0); hdr(8'h02, 24'h000010); xbyte(8'h5A, rb); desel();
    rd1(1'b0, 24'h000010, v); chk("R8 write w/o latch", v, 8'h00);

    cmd1(1'b0, 8'h06); rdsr(1'b1, v); chk("R1 R8 set latch", v, 8'h02);
    cmd1(1'b1, 8'h04); rdsr(1'b0, v); chk("R1 R8 clear latch", v, 8'h00);

    // R7 R3: status write, MSB first, latch cleared on deselect
    cmd1(1'b0, 8'h06); sel(1'b0); xbyte(8'h01, rb); xbyte(8'h84, rb); desel();
    rdsr(1'b0, v); chk("R7 R3 status write 84", v, 8'h84);
    cmd1(1'b0, 8'h06); sel(1'b1); xbyte(8'h01, rb); xbyte(8'hFF, rb); desel();
    sel(1'b0); xbyte(8'h05, rb); xbyte(8'h00, v); xbyte(8'h00, v2); desel();
    chk("R7 status mask", v, 8'hFC); chk("R7 status repeat", v2, 8'hFC);
    sel(1'b0); xbyte(8'h01, rb); xbyte(8'h00, rb); desel();
    rdsr(1'b0, v); chk("R8 status write w/o latch", v, 8'hFC);
    cmd1(1'b0, 8'h06); sel(1'b0); xbyte(8'h01, rb); xbyte(8'h00, rb); desel();
    rdsr(1'b0, v); chk("R7 status restore", v, 8'h00);

    // R9 R5: full-array burst write in idle-high mode
    cmd1(1'b1, 8'h06);
    sel(1'b1); hdr(8'h02, 24'h000000);
    for (int a = 0; a < 256; a++) xbyte(pat(a), rb);
    desel();
    rdsr(1'b0, v); chk("R8 latch cleared after write", v, 8'h00);

    // R9 R3 R6: full-array burst read in idle-low mode
    sel(1'b0); hdr(8'h03, 24'h000000);
    for (int a = 0; a < 256; a++) begin
      xbyte(8'h00, v); chk("R9 R3 burst read mode0", v, pat(a));
    end
    chk("R6 oe during read", {7'd0, so_oe}, 8'h01);
    desel();
    chk("R6 oe after desel", {7'd0, so_oe}, 8'h00);

    sel(1'b1); hdr(8'h03, 24'h000080);
    for (int a = 128; a < 144; a++) begin
      xbyte(8'h00, v); chk("R5 burst read mode3", v, pat(a));
    end
    desel();

    // R4: upper address bits ignored
    cmd1(1'b0, 8'h06); sel(1'b0); hdr(8'h02, 24'hF80010); xbyte(8'hC3, rb); desel();
    rd1(1'b1, 24'h000010, v); chk("R4 upper bits ignored", v, 8'hC3);

    // R9: wrap at top of 19-bit space
    cmd1(1'b0, 8'h06); sel(1'b0); hdr(8'h02, 24'h07FFFF);
    xbyte(8'hA5, rb); xbyte(8'h5A, rb); desel();
    rd1(1'b0, 24'h000000, v); chk("R9 wrap to zero", v, 8'h5A);
    sel(1'b0); hdr(8'h03, 24'h07FFFF); xbyte(8'h00, v); xbyte(8'h00, v2); desel();
    chk("R9 read top", v, 8'hA5); chk("R9 read wrap", v2, 8'h5A);

    // R2: invalid command silences the rest
    sel(1'b1); xbyte(8'h0B, rb); xbyte(8'h06, rb);
    chk("R2 oe low after bad cmd", {7'd0, so_oe}, 8'h00);
    xbyte(8'h05, v); chk("R2 so idle after bad cmd", {7'd0, so_oe}, 8'h00);
    desel();
    rdsr(1'b0, v); chk("R2 bad cmd ignored", v, 8'h00);
    sel(1'b0); xbyte(8'h07, rb); xbyte(8'h06, rb); desel();
    rdsr(1'b1, v); chk("R2 bad cmd mode0", v, 8'h00);

    // R10: partial byte discarded on deselect
    sel(1'b0); xbits(4, 8'h00, rb); desel();
    cmd1(1'b0, 8'h06); rdsr(1'b0, v); chk("R10 partial discarded", v, 8'h02);
    sel(1'b1); xbits(5, 8'h06, rb); desel();
    cmd1(1'b1, 8'h04); rdsr(1'b1, v); chk("R10 abort mode3", v, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule